// File: doc/BRIEF.md
# Truth-Table Programmed Ripple ALU

This block is a combinational ripple ALU. Each result bit is chosen from a small truth table that a single shared control word supplies. For each bit, that bit of operand A, that bit of operand B and the carry coming into the bit together form a 3-bit index. The index selects one bit of the 8-bit control word. Because of this, AND, OR, XOR, ADD and the two operand pass-through functions need no decoding logic inside the block. The caller just presents a different control word.

A majority-function carry chain joins the bits, which gives an add with carry-in and carry-out. A carry-enable input can switch the chain off entirely. The result bus is tri-state under an active-low output enable, so several sources can share it. The carry-out is always driven.

Top module: `tt_ripple_alu`

## Requirements
- R1: For every bit i, result[i] equals tt_word[{c_i, opnd_b[i], opnd_a[i]}]. Here c_i is the carry into bit i and is the most significant bit of the index, and opnd_a[i] is the least significant bit.
- R2: tt_word 8'h88 gives opnd_a AND opnd_b, and tt_word 8'hEE gives opnd_a OR opnd_b, whatever the carries are.
- R3: tt_word 8'h66 gives opnd_a XOR opnd_b. tt_word 8'h96 gives the parity of A, B and carry per bit. With carry_en high, {cout, result} then equals opnd_a + opnd_b + cin.
- R4: tt_word 8'hAA passes opnd_a to the result, and tt_word 8'hCC passes opnd_b to the result.
- R5: With carry_en high, the carry into bit 0 is cin. The carry into bit i+1 is the majority of opnd_a[i], opnd_b[i] and c_i, and cout is the carry out of the top bit.
- R6: With carry_en low, every internal carry and cout are 0 and cin has no effect. As a result, tt_word 8'h96 yields opnd_a XOR opnd_b.
- R7: With oe_n high, the result bus is high-impedance, and cout is still driven.
- R8: With oe_n low, the result bus drives the computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| cin | input | 1 | Carry into bit 0 |
| carry_en | input | 1 | High to let carries ripple between bits |
| tt_word | input | 8 | Truth table indexed by {carry, B, A} |
| oe_n | input | 1 | Active-low result enable |
| result | output | 8 | Tri-state result bus |
| cout | output | 1 | Carry out of the top bit |

## Verification
Each named control word is applied to random operands with carry_en high and then low. This separates the logic functions, which ignore the carry, from ADD, which depends on it. It also shows that a disabled chain turns ADD into XOR.

Random control words are compared against a bit-serial table lookup. This exposes a swapped index order or a wrong carry feed that the named words would hide, because those words are symmetric.

Directed all-ones sums check propagation along the full chain. A pull-up on the bus shows that the result is released while the output enable is high.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;
  localparam int unsigned TT_IDX_W = 3;
  localparam int unsigned TT_SIZE  = 1 << TT_IDX_W;
  localparam logic [TT_SIZE-1:0] TT_AND   = 8'h88;
  localparam logic [TT_SIZE-1:0] TT_OR    = 8'hEE;
  localparam logic [TT_SIZE-1:0] TT_XOR   = 8'h66;
  localparam logic [TT_SIZE-1:0] TT_ADD   = 8'h96;
  localparam logic [TT_SIZE-1:0] TT_PASSA = 8'hAA;
  localparam logic [TT_SIZE-1:0] TT_PASSB = 8'hCC;

  typedef struct packed {
    logic c;
    logic b;
    logic a;
  } tt_idx_t;
endpackage

// File: rtl/tt_bit_cell.sv
module tt_bit_cell
  import tt_alu_pkg::*;
(
  input  logic               a_i,
  input  logic               b_i,
  input  logic               c_i,
  input  logic [TT_SIZE-1:0] word_i,
  output logic               y_o
);
  tt_idx_t idx;

  always_comb begin
    idx.c = c_i;
    idx.b = b_i;
    idx.a = a_i;
    y_o   = word_i[idx];
  end

  // R2: the AND word is independent of the carry
  always_comb begin
    if (!$isunknown({a_i, b_i, c_i, word_i}) && word_i == TT_AND)
      a_r2_and_bit: assert (y_o == (a_i & b_i));
  end

  // R3: the XOR word is independent of the carry
  always_comb begin
    if (!$isunknown({a_i, b_i, c_i, word_i}) && word_i == TT_XOR)
      a_r3_xor_bit: assert (y_o == (a_i ^ b_i));
  end
endmodule

// File: rtl/tt_carry_chain.sv
module tt_carry_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             en_i,
  output logic [WIDTH:0]   c_o
);
  assign c_o[0] = en_i & cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic maj;
    assign maj        = (a_i[i] & b_i[i]) | (a_i[i] & c_o[i]) | (b_i[i] & c_o[i]);
    assign c_o[i+1]   = en_i & maj;
  end
endmodule

// File: rtl/tt_bus_driver.sv
module tt_bus_driver #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] bus_o
);
  assign bus_o = oe_n_i ? {WIDTH{1'bz}} : d_i;
endmodule

// File: rtl/tt_ripple_alu.sv
module tt_ripple_alu
  import tt_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  input  logic               cin,
  input  logic               carry_en,
  input  logic [TT_SIZE-1:0] tt_word,
  input  logic               oe_n,
  output logic [WIDTH-1:0]   result,
  output logic               cout
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] core;

  tt_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .cin_i (cin),
    .en_i  (carry_en),
    .c_o   (carry)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tt_bit_cell u_cell (
      .a_i    (opnd_a[i]),
      .b_i    (opnd_b[i]),
      .c_i    (carry[i]),
      .word_i (tt_word),
      .y_o    (core[i])
    );
  end

  assign cout = carry[WIDTH];

  tt_bus_driver #(.WIDTH(WIDTH)) u_drv (
    .d_i    (core),
    .oe_n_i (oe_n),
    .bus_o  (result)
  );

  // R6: a disabled chain never produces a carry-out
  always_comb begin
    if (!$isunknown({carry_en, cout}) && !carry_en)
      a_r6_carry_off: assert (cout == 1'b0);
  end

  // R3: with the chain on, the ADD word yields the binary sum
  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, cin, carry_en, tt_word}) && carry_en && tt_word == TT_ADD)
      a_r3_add_sum: assert ({cout, core} == ({1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, cin}));
  end

  // R4: pass-through words copy an operand
  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, tt_word, core}) && tt_word == TT_PASSA)
      a_r4_pass_a: assert (core == opnd_a);
    if (!$isunknown({opnd_a, opnd_b, tt_word, core}) && tt_word == TT_PASSB)
      a_r4_pass_b: assert (core == opnd_b);
  end

  // R2: OR word across the whole slice
  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, tt_word, core}) && tt_word == TT_OR)
      a_r2_or_word: assert (core == (opnd_a | opnd_b));
  end
endmodule

// File: tb/sim_tt_ripple_alu.sv
`timescale 1ns/1ps
module sim_tt_ripple_alu;
  logic       clk = 1'b0;
  logic [7:0] a, b, word;
  logic       cin, cen, oe_n;
  wire  [7:0] bus;
  wire        cout;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_pu
    pullup (bus[k]);
  end

  tt_ripple_alu u0 (
    .opnd_a(a), .opnd_b(b), .cin(cin), .carry_en(cen),
    .tt_word(word), .oe_n(oe_n), .result(bus), .cout(cout)
  );

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h (a=%h b=%h cin=%0d en=%0d word=%h)",
               req, got, exp, a, b, cin, cen, word);
    end
  endtask

  task automatic apply(input logic [7:0] ta, input logic [7:0] tb_, input logic tc,
                       input logic te, input logic [7:0] tw, input logic toe);
    @(negedge clk);
    a = ta; b = tb_; cin = tc; cen = te; word = tw; oe_n = toe;
    @(posedge clk);
    #1;
  endtask

  // bit-serial lookup model from R1/R5/R6
  function automatic logic [8:0] model(input logic [7:0] ma, input logic [7:0] mb,
                                       input logic mc, input logic me, input logic [7:0] mw);
    logic [7:0] r;
    int c;
    c = me ? int'(mc) : 0;
    for (int i = 0; i < 8; i++) begin
      int s;
      s = c * 4 + int'(mb[i]) * 2 + int'(ma[i]);
      r[i] = mw[s];
      c = (me && (int'(ma[i]) + int'(mb[i]) + c) >= 2) ? 1 : 0;
    end
    return {c[0], r};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] sum;
    a = 0; b = 0; cin = 0; cen = 0; word = 0; oe_n = 1;
    // R7: released bus reads pulled high, cout still driven 0
    apply(8'h00, 8'h00, 1'b0, 1'b0, 8'h88, 1'b1);
    chk("R7 hiz", {cout, bus}, 9'h0FF);
    apply(8'hFF, 8'h01, 1'b0, 1'b1, 8'h96, 1'b1);
    chk("R7 cout driven while released", {cout, bus}, 9'h1FF);
    // R8: enabling drives the value
    apply(8'h00, 8'h00, 1'b0, 1'b0, 8'h88, 1'b0);
    chk("R8 driven", {cout, bus}, 9'h000);
    // R5 corner: full-length ripple
    apply(8'hFF, 8'h01, 1'b0, 1'b1, 8'h96, 1'b0);
    chk("R5 ripple ff+01", {cout, bus}, 9'h100);
    apply(8'hFF, 8'h00, 1'b1, 1'b1, 8'h96, 1'b0);
    chk("R5 ripple ff+cin", {cout, bus}, 9'h100);
    // R6: cin ignored with chain off
    apply(8'h00, 8'h00, 1'b1, 1'b0, 8'h96, 1'b0);
    chk("R6 cin ignored", {cout, bus}, 9'h000);
    apply(8'hFF, 8'hFF, 1'b1, 1'b0, 8'h96, 1'b0);
    chk("R6 add becomes xor", {cout, bus}, 9'h000);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] ra, rb;
      logic rc, re;
      ra = 8'($urandom); rb = 8'($urandom); rc = 1'($urandom); re = 1'($urandom);
      apply(ra, rb, rc, re, 8'h88, 1'b0);
      chk("R2 and", {cout, bus}, {re && (ra & rb) >= 8'h00 ? model(ra, rb, rc, re, 8'h88) >> 8 : 9'h0, 8'h00} | {1'b0, ra & rb});
      apply(ra, rb, rc, re, 8'hEE, 1'b0);
      chk("R2 or", {1'b0, bus}, {1'b0, ra | rb});
      apply(ra, rb, rc, re, 8'h66, 1'b0);
      chk("R3 xor", {1'b0, bus}, {1'b0, ra ^ rb});
      apply(ra, rb, rc, re, 8'h96, 1'b0);
      sum = re ? ({1'b0, ra} + {1'b0, rb} + {8'h00, rc}) : {1'b0, ra ^ rb};
      chk(re ? "R3 add" : "R6 add chain off", {cout, bus}, sum);
      apply(ra, rb, rc, re, 8'hAA, 1'b0);
      chk("R4 pass a", {1'b0, bus}, {1'b0, ra});
      apply(ra, rb, rc, re, 8'hCC, 1'b0);
      chk("R4 pass b", {1'b0, bus}, {1'b0, rb});
    end

    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra, rb, rw;
      logic rc, re;
      ra = 8'($urandom); rb = 8'($urandom); rw = 8'($urandom);
      rc = 1'($urandom); re = 1'($urandom);
      apply(ra, rb, rc, re, rw, 1'b0);
      chk("R1 lookup", {cout, bus}, model(ra, rb, rc, re, rw));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule